// File: doc/BRIEF.md
# Programmable priority interrupt resolver

This block picks, for each of two interrupt classes, the one active source that software ranks highest. The ranking is a table of 40 slots. Each slot holds a source number from 0 to 39 and an enable flag. Software can rewrite the table at any time, so the priority order is a remappable list and does not follow the source numbers. The block takes two 40-bit inputs. The first is a vector of sources that are already pending and unmasked. The second is a steering vector that puts each source in the fast class (bit set) or the normal class (bit clear).

The block scans the table from slot 0 upward and finds the first enabled slot whose source is active in each class. It reports both results in one 32-bit status word. Each half of the word has its own hit flag. The slots and the status word are read through one registered read port, and the slots are written through a simple write strobe. Both ports use byte offsets.

Top module: `prio_resolver`

## Requirements
- R1: After reset every slot reads 0, `rd_data` is 0, and a status read returns 0x003F003F.
- R2: A slot write keeps only bit 31 (enable) and bits 5:0 (source number) of `wr_data`. Slot reads return the written value AND 0x8000003F.
- R3: Slots 0..31 sit at byte offsets 0x1C + 4*i. Slots 32..39 sit at 0xB0 + 4*(i-32). Writes to any other offset, including offsets that are not word aligned, change nothing. Reads of unmapped offsets return 0.
- R4: A slot takes part only when its enable bit is set and its source number is below 40. Source numbers 40..63 never win, even when `act_vec` bit (number mod 32) is set.
- R5: Among the qualifying slots whose source is a candidate, the one with the lowest slot index wins. This holds whatever the source numbers are.
- R6: A source is a fast-class candidate when `act_vec` and `fiq_sel` are both set for it. The fast winner is reported at status bit 15 (hit) and bits 5:0 (source number).
- R7: A source is a normal-class candidate when `act_vec` is set and `fiq_sel` is clear for it. The normal winner is reported at status bit 31 (hit) and bits 21:16 (source number).
- R8: A class with no winner reads with its hit bit clear and source field 0x3F. All other status bits are always 0.
- R9: A read sampled with `rd_en` high at a clock edge shows on `rd_data` after that edge. The value reflects the slots and inputs as they were before that edge, so a write in the same cycle is not yet visible. `rd_data` holds its value while `rd_en` is low.
- R10: Several slots may name the same source, and the lowest of them ranks it. The two classes resolve independently and can both hit in the same status word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_vec | input | 40 | Pending-and-unmasked source vector |
| fiq_sel | input | 40 | Class steering, 1 = fast class |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 8 | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Read byte offset; 0x18 selects the status word |
| rd_data | output | 32 | Registered read data |

## Verification
A corrupted slot register does not show up on its own. It only appears when a status read takes place while the slot's source, or a lower-ranked competing source, is active. The fault then shows on the very next read as a wrong source number or a missing hit. So the scenarios place active sources at several table positions and in both classes. They re-read the slots through the read port so that a bad stored value is seen directly and not only through the status word. A wrong class decision shows up as a source reported in the half of the word that does not match its steering bit, and the checker flags that on the cycle after the read.

// File: rtl/prio_res_pkg.sv
package prio_res_pkg;
    localparam int NUM_SRC    = 40;
    localparam int NUM_SLOTS  = 40;
    localparam int LO_SLOTS   = 32;
    localparam int ID_W       = 6;
    localparam int DATA_W     = 32;
    localparam int ADDR_W     = 8;
    localparam int LO_BASE    = 'h1C;
    localparam int HI_BASE    = 'hB0;
    localparam int STATUS_OFS = 'h18;
    localparam int EN_BIT     = 31;
    localparam int FAST_HIT   = 15;
    localparam int NORM_HIT   = 31;
    localparam int NORM_ID_LO = 16;
    localparam logic [DATA_W-1:0] SLOT_MASK = 32'h8000_003F;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } win_t;
endpackage

// File: rtl/prio_addr_dec.sv
module prio_addr_dec
    import prio_res_pkg::*;
#(
    parameter int AW     = ADDR_W,
    parameter int NSLOT  = NUM_SLOTS,
    parameter int NLO    = LO_SLOTS,
    parameter int BASE_L = LO_BASE,
    parameter int BASE_H = HI_BASE
) (
    input  logic [AW-1:0]             addr,
    output logic                      hit,
    output logic [$clog2(NSLOT)-1:0]  idx
);
    localparam int IDX_W = $clog2(NSLOT);
    localparam int END_L = BASE_L + 4 * NLO;
    localparam int END_H = BASE_H + 4 * (NSLOT - NLO);

    always_comb begin
        int a;
        a   = int'(addr);
        hit = 1'b0;
        idx = '0;
        if (a[1:0] == 2'b00) begin
            if (a >= BASE_L && a < END_L) begin
                hit = 1'b1;
                idx = IDX_W'((a - BASE_L) / 4);
            end else if (a >= BASE_H && a < END_H) begin
                hit = 1'b1;
                idx = IDX_W'(NLO + (a - BASE_H) / 4);
            end
        end
    end
endmodule

// File: rtl/prio_slot_bank.sv
module prio_slot_bank
    import prio_res_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int DW    = DATA_W
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic                            wr_hit,
    input  logic [$clog2(NSLOT)-1:0]        wr_idx,
    input  logic [DW-1:0]                   wr_data,
    output logic [NSLOT-1:0][DW-1:0]        slots
);
    typedef struct packed {
        logic [NSLOT-1:0][DW-1:0] word;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NSLOT; i++) begin
            if (wr_en && wr_hit && int'(wr_idx) == i) begin
                bank_d.word[i] = wr_data & SLOT_MASK;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    assign slots = bank_q.word;
endmodule

// File: rtl/prio_winner_scan.sv
module prio_winner_scan
    import prio_res_pkg::*;
#(
    parameter int NSLOT = NUM_SLOTS,
    parameter int NS    = NUM_SRC,
    parameter int IW    = ID_W
) (
    input  logic [NSLOT-1:0]         slot_en,
    input  logic [NSLOT-1:0][IW-1:0] slot_id,
    input  logic [NS-1:0]            cand,
    output win_t                     win
);
    localparam int EXT = 2 ** IW;

    logic [EXT-1:0] cand_ext;
    assign cand_ext = {{(EXT - NS){1'b0}}, cand};

    // Walk from the lowest-ranked slot up so the last hit is the highest rank.
    always_comb begin
        win.hit = 1'b0;
        win.id  = '1;
        for (int j = NSLOT - 1; j >= 0; j--) begin
            if (slot_en[j] && int'(slot_id[j]) < NS && cand_ext[slot_id[j]]) begin
                win.hit = 1'b1;
                win.id  = slot_id[j];
            end
        end
    end
endmodule

// File: rtl/prio_resolver.sv
module prio_resolver
    import prio_res_pkg::*;
#(
    parameter int NS    = NUM_SRC,
    parameter int NSLOT = NUM_SLOTS,
    parameter int AW    = ADDR_W,
    parameter int DW    = DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NS-1:0] act_vec,
    input  logic [NS-1:0] fiq_sel,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);
    localparam int IDX_W  = $clog2(NSLOT);
    localparam int NCLASS = 2;

    logic                      wr_hit, rd_hit;
    logic [IDX_W-1:0]          wr_idx, rd_idx;
    logic [NSLOT-1:0][DW-1:0]  slots;
    logic [NSLOT-1:0]          slot_en;
    logic [NSLOT-1:0][ID_W-1:0] slot_id;
    win_t                      win [NCLASS];
    logic [DW-1:0]             status;

    prio_addr_dec #(.AW(AW), .NSLOT(NSLOT)) u_wr_dec (
        .addr(wr_addr), .hit(wr_hit), .idx(wr_idx)
    );
    prio_addr_dec #(.AW(AW), .NSLOT(NSLOT)) u_rd_dec (
        .addr(rd_addr), .hit(rd_hit), .idx(rd_idx)
    );

    prio_slot_bank #(.NSLOT(NSLOT), .DW(DW)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hit(wr_hit),
        .wr_idx(wr_idx), .wr_data(wr_data), .slots(slots)
    );

    always_comb begin
        for (int i = 0; i < NSLOT; i++) begin
            slot_en[i] = slots[i][EN_BIT];
            slot_id[i] = slots[i][ID_W-1:0];
        end
    end

    // Class 0 is the fast (steered) class, class 1 the normal class.
    for (genvar g = 0; g < NCLASS; g++) begin : g_class
        logic [NS-1:0] cand;
        assign cand = (g == 0) ? (act_vec & fiq_sel) : (act_vec & ~fiq_sel);
        prio_winner_scan #(.NSLOT(NSLOT), .NS(NS), .IW(ID_W)) u_scan (
            .slot_en(slot_en), .slot_id(slot_id), .cand(cand), .win(win[g])
        );
    end

    always_comb begin
        status                        = '0;
        status[FAST_HIT]              = win[0].hit;
        status[ID_W-1:0]              = win[0].id;
        status[NORM_HIT]              = win[1].hit;
        status[NORM_ID_LO +: ID_W]    = win[1].id;
    end

    typedef struct packed {
        logic [DW-1:0] rdata;
    } rd_t;

    rd_t rd_d, rd_q;

    always_comb begin
        rd_d = rd_q;
        if (rd_en) begin
            if (int'(rd_addr) == STATUS_OFS) rd_d.rdata = status;
            else if (rd_hit)                 rd_d.rdata = slots[rd_idx];
            else                             rd_d.rdata = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_q <= '0;
        else        rd_q <= rd_d;
    end

    assign rd_data = rd_q.rdata;
endmodule

// File: rtl/prio_resolver_chk.sv
module prio_resolver_chk
    import prio_res_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic [NUM_SRC-1:0] act_vec,
    input logic [NUM_SRC-1:0] fiq_sel,
    input logic              rd_en,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [DATA_W-1:0] rd_data
);
    localparam int EXT = 2 ** ID_W;

    logic           armed_q, st_q, slot_q, idle_q;
    logic [EXT-1:0] fastc_q, normc_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed_q <= 1'b0;
            st_q    <= 1'b0;
            slot_q  <= 1'b0;
            idle_q  <= 1'b0;
            fastc_q <= '0;
            normc_q <= '0;
        end else begin
            armed_q <= 1'b1;
            st_q    <= rd_en && int'(rd_addr) == STATUS_OFS;
            slot_q  <= rd_en && int'(rd_addr) != STATUS_OFS;
            idle_q  <= !rd_en;
            fastc_q <= {{(EXT - NUM_SRC){1'b0}}, act_vec & fiq_sel};
            normc_q <= {{(EXT - NUM_SRC){1'b0}}, act_vec & ~fiq_sel};
        end
    end

    assert_fast_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && st_q && !rd_data[FAST_HIT] |-> rd_data[ID_W-1:0] == 6'h3F);

    assert_norm_empty_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && st_q && !rd_data[NORM_HIT] |-> rd_data[NORM_ID_LO +: ID_W] == 6'h3F);

    assert_status_rsvd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && st_q |-> rd_data[30:22] == '0 && rd_data[14:6] == '0);

    assert_fast_cand_R6: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && st_q && rd_data[FAST_HIT] |-> fastc_q[rd_data[ID_W-1:0]]);

    assert_norm_cand_R7: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && st_q && rd_data[NORM_HIT] |-> normc_q[rd_data[NORM_ID_LO +: ID_W]]);

    assert_slot_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && slot_q |-> rd_data[30:6] == '0);

    assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        armed_q && idle_q |-> $stable(rd_data));
endmodule

bind prio_resolver prio_resolver_chk u_chk (.*);

// File: tb/prio_resolver_tb.sv
`timescale 1ns/1ps
module prio_resolver_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [39:0] act_vec = '0;
    logic [39:0] fiq_sel = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [7:0]  rd_addr = '0;
    logic [31:0] rd_data;

    always #2 clk = ~clk;

    prio_resolver u_dut (.*);

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mdl [40];
    logic [31:0] exp_q [$];
    string       tag_q [$];
    logic        rd_seen = 1'b0;

    function automatic logic [7:0] slot_addr(int i);
        return (i < 32) ? 8'(28 + 4 * i) : 8'(176 + 4 * (i - 32));
    endfunction

    function automatic logic [31:0] exp_status();
        logic [31:0] r;
        logic fd, nd;
        int s;
        r = 32'h003F003F; fd = 0; nd = 0;
        for (int j = 0; j < 40; j++) begin
            s = int'(mdl[j][5:0]);
            if (mdl[j][31] && s < 40 && act_vec[s]) begin
                if (fiq_sel[s] && !fd) begin
                    r[15] = 1'b1; r[5:0] = 6'(s); fd = 1;
                end
                if (!fiq_sel[s] && !nd) begin
                    r[31] = 1'b1; r[21:16] = 6'(s); nd = 1;
                end
            end
        end
        return r;
    endfunction

    task automatic check(input logic ok, input string tag,
                         input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    task automatic wr_raw(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_slot(input int i, input logic [31:0] d);
        wr_raw(slot_addr(i), d);
        mdl[i] = d & 32'h8000003F;
    endtask

    task automatic rd_push(input logic [7:0] a, input logic [31:0] exp, input string tag);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic rd_status(input string tag);
        rd_push(8'h18, exp_status(), tag);
    endtask

    task automatic clear_slots();
        for (int i = 0; i < 40; i++) if (mdl[i] != 0) wr_slot(i, 32'h0);
    endtask

    // Monitor: compare each registered read result against the scoreboard.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen && exp_q.size() > 0) begin
            logic [31:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            check(rd_data === e, t, rd_data, e);
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: got %0d expected 0 pending", exp_q.size());
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        for (int i = 0; i < 40; i++) mdl[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rd_data === 32'h0, "R1 rd_data at reset", rd_data, 32'h0);
        rd_status("R1 status after reset");
        rd_push(slot_addr(0), 32'h0, "R1 slot0 after reset");
        rd_push(slot_addr(39), 32'h0, "R1 slot39 after reset");

        // R2 masking
        wr_slot(0, 32'hFFFF_FFFF);
        rd_push(slot_addr(0), 32'h8000_003F, "R2 full write masked");
        wr_slot(17, 32'h7FFF_FFC5);
        rd_push(slot_addr(17), 32'h0000_0005, "R2 no enable kept");

        // R3 map and ignored offsets
        wr_slot(31, 32'h8000_0011);
        rd_push(8'h98, 32'h8000_0011, "R3 slot31 offset");
        wr_slot(39, 32'h8000_0022);
        rd_push(8'hCC, 32'h8000_0022, "R3 slot39 offset");
        wr_slot(32, 32'h8000_0003);
        rd_push(8'hB0, 32'h8000_0003, "R3 slot32 offset");
        wr_raw(8'h9C, 32'h8000_0001);
        wr_raw(8'h1D, 32'h8000_0002);
        wr_raw(8'hD0, 32'h8000_0004);
        rd_push(8'h9C, 32'h0, "R3 unmapped read");
        rd_push(8'hD0, 32'h0, "R3 past end read");
        rd_push(slot_addr(0), mdl[0], "R3 misaligned write ignored");
        rd_push(slot_addr(1), 32'h0, "R3 gap write ignored");
        clear_slots();

        // R5/R7/R8 normal class ordering
        wr_slot(0, 32'h8000_0005);
        wr_slot(1, 32'h8000_0003);
        wr_slot(2, 32'h8000_000C);
        act_vec = (40'd1 << 3) | (40'd1 << 12);
        rd_push(8'h18, 32'h8003_003F, "R7 normal winner slot1");
        act_vec = act_vec | (40'd1 << 5);
        rd_push(8'h18, 32'h8005_003F, "R5 lower slot wins");
        fiq_sel = 40'd1 << 5;
        rd_push(8'h18, 32'h8003_8005, "R6 R10 both classes");
        fiq_sel = (40'd1 << 5) | (40'd1 << 12);
        rd_status("R6 fast winner priority");
        act_vec = 40'd1 << 12; fiq_sel = '0;
        rd_push(8'h18, 32'h800C_003F, "R8 empty fast half");
        clear_slots();

        // R4 qualification
        wr_slot(3, 32'h0000_0027);
        act_vec = 40'd1 << 39; fiq_sel = '0;
        rd_push(8'h18, 32'h003F_003F, "R4 disabled slot");
        wr_slot(3, 32'h8000_002D);
        act_vec = 40'd1 << 13;
        rd_push(8'h18, 32'h003F_003F, "R4 id above range");
        wr_slot(5, 32'h8000_000D);
        rd_push(8'h18, 32'h800D_003F, "R4 valid slot behind bad slot");
        clear_slots();

        // R10 duplicates, upper bank ranking
        wr_slot(7, 32'h8000_0014);
        wr_slot(4, 32'h8000_0014);
        wr_slot(35, 32'h8000_0026);
        act_vec = (40'd1 << 20) | (40'd1 << 38); fiq_sel = 40'd1 << 20;
        rd_push(8'h18, 32'h8026_8014, "R10 duplicate source");
        wr_slot(4, 32'h0);
        rd_status("R10 remaining duplicate");
        fiq_sel = (40'd1 << 20) | (40'd1 << 38);
        rd_push(8'h18, 32'h003F_8014, "R5 upper bank loses to slot7");

        // R9 hold and read-before-write
        @(negedge clk);
        repeat (2) @(negedge clk);
        held = rd_data;
        act_vec = '0;
        repeat (2) @(negedge clk);
        check(rd_data === held, "R9 hold while idle", rd_data, held);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = slot_addr(6); wr_data = 32'h8000_0009;
        rd_en = 1'b1; rd_addr = slot_addr(6);
        exp_q.push_back(mdl[6]); tag_q.push_back("R9 same-cycle write not visible");
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        mdl[6] = 32'h8000_0009;
        rd_push(slot_addr(6), 32'h8000_0009, "R9 write visible next read");

        repeat (4) @(negedge clk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule